// File: doc/BRIEF.md
# Clock Output Gating and Stop Controller

This block sits between the internal clock sources of a motherboard clock generator and its output pins. It receives a CPU-rate clock, a 48/24 MHz peripheral clock and a 14.318 MHz reference clock. From the CPU-rate clock it makes a half-rate PCI clock. Each output is switched on or off by its own bit in a small byte-wide register bank, and groups of outputs are also silenced by stop requests and by a global power-down input.

Two output pins are shared. When the mode input is high, they drive the two upper SDRAM clocks. When it is low, the block releases them (output enable low) and treats what the board drives on them as the CPU stop and PCI stop requests. Each stop or enable change is resynchronised into the domain of the clock it controls. The change is applied only while that clock is low, so an output never shows a shortened high pulse. The PCI divider keeps running while PCI outputs are stopped, so a restart returns in the same phase as before.

Top module: `clk_stop_gate`

## Requirements
- R1: After reset every implemented enable bit is 1. A read of address 3 returns 8'hFF, address 2 returns 8'h7F, address 1 returns 8'hCF and address 5 returns 8'h13. All outputs toggle once reset has been released.
- R2: Register layout. Address 1: bits 0..3 enable CPU clocks 0..3, bits 6 and 7 enable peripheral clocks 0 and 1. Address 2: bits 0..5 enable PCI clocks 0..5, bit 6 enables the free-running PCI clock. Address 3: bits 0..7 enable SDRAM clocks 0..7. Address 5: bits 0 and 1 enable reference clocks 0 and 1, bit 4 enables the interrupt-controller clock. Every other bit, and addresses 0, 4, 6 and 7, read as 0 whatever was written, and writes to them change no output.
- R3: An output whose enable bit is 0 stays low. An output whose bit is 1 toggles at the rate of its source.
- R4: With mode low and shared pin 6 input at 1, all four CPU clock outputs stay low and every other output is unaffected.
- R5: With mode low and shared pin 7 input at 1, PCI clocks 0..5 stay low while the free-running PCI clock keeps toggling.
- R6: With mode high, both shared pins have output enable 1, they carry SDRAM clocks 6 and 7, and their inputs have no stop effect. With mode low, both output enables are 0 and both pin outputs stay low.
- R7: While the power-down input is 1, every clock output is low, independent of any other control.
- R8: The PCI clocks run at exactly half the CPU clock rate.
- R9: Gating changes never produce a shortened high pulse: every high pulse on a gated output lasts a full high phase of its source clock.
- R10: PCI clocks 0..5 stay in phase with the free-running PCI clock after a stop is released: each rises only together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-bank clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_clk | input | 1 | CPU-rate source clock |
| usb_clk | input | 1 | 48/24 MHz peripheral source clock |
| ref_clk | input | 1 | 14.318 MHz reference source clock |
| pwr_dwn | input | 1 | 1 forces all outputs low |
| mode | input | 1 | 1: shared pins are SDRAM outputs; 0: shared pins are stop inputs |
| sd6_in | input | 1 | Shared pin 6 input value (CPU stop when mode is 0) |
| sd7_in | input | 1 | Shared pin 7 input value (PCI stop when mode is 0) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write byte address |
| wr_data | input | 8 | Register write byte |
| rd_addr | input | 3 | Register read byte address |
| rd_data | output | 8 | Register read byte |
| cpu_clk_o | output | 4 | Gated CPU clocks |
| pci_clk_o | output | 6 | Gated stoppable PCI clocks |
| pci_free_o | output | 1 | Free-running PCI clock |
| sdram_clk_o | output | 6 | Gated SDRAM clocks 0..5 |
| sd6_out | output | 1 | Shared pin 6 output value (SDRAM clock 6) |
| sd6_oe | output | 1 | Shared pin 6 output enable |
| sd7_out | output | 1 | Shared pin 7 output value (SDRAM clock 7) |
| sd7_oe | output | 1 | Shared pin 7 output enable |
| usb_clk_o | output | 2 | Gated peripheral clocks |
| ref_clk_o | output | 2 | Gated reference clocks |
| apic_clk_o | output | 1 | Gated interrupt-controller clock |

## Verification
The assertions check the following on every edge of the relevant clock: a gate never moves while its clock is high, power-down leaves all outputs low, a synchronised CPU or PCI stop has silenced its group, a held high mode keeps the stop inactive, and reserved bytes and bits read zero. Only the bench scenarios can show that enabled outputs really toggle and at which rate. They also show that the PCI-to-CPU ratio is two, that the free clock survives a PCI stop and stays in phase with the stoppable PCI clocks, and that rapid, misaligned stop toggling leaves no short pulse on any output.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the clock gating controller.
// Assumes a byte-wide register bank with a 3-bit address.
package cg_pkg;
    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;
    localparam int N_CPU  = 4;
    localparam int N_PCI  = 6;
    localparam int N_SDR  = 8;
    localparam int N_USB  = 2;
    localparam int N_REF  = 2;

    localparam logic [ADDR_W-1:0] A_CPU   = 3'd1;
    localparam logic [ADDR_W-1:0] A_PCI   = 3'd2;
    localparam logic [ADDR_W-1:0] A_SDR   = 3'd3;
    localparam logic [ADDR_W-1:0] A_PER   = 3'd5;

    // writable-bit masks; all other bits read as zero
    localparam logic [BYTE_W-1:0] M_CPU = 8'hCF;
    localparam logic [BYTE_W-1:0] M_PCI = 8'h7F;
    localparam logic [BYTE_W-1:0] M_SDR = 8'hFF;
    localparam logic [BYTE_W-1:0] M_PER = 8'h13;

    typedef struct packed {
        logic [N_USB-1:0] usb;
        logic [N_CPU-1:0] cpu;
        logic             free;
        logic [N_PCI-1:0] pci;
        logic [N_SDR-1:0] sdr;
        logic             apic;
        logic [N_REF-1:0] refc;
    } cg_en_t;
endpackage

// File: rtl/cg_regbank.sv
`timescale 1ns/1ps
// Byte-wide enable register bank. Holds one active-high enable per output.
// Only the masked bits are stored; reserved bits and unused addresses read
// as zero. Assumes wr_* are synchronous to clk.
module cg_regbank
    import cg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output cg_en_t            en
);
    logic [BYTE_W-1:0] r_cpu, r_pci, r_sdr, r_per;

    // Store masked write data; reset turns every output on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_cpu <= M_CPU;
            r_pci <= M_PCI;
            r_sdr <= M_SDR;
            r_per <= M_PER;
        end else if (wr_en) begin
            case (wr_addr)
                A_CPU:   r_cpu <= wr_data & M_CPU;
                A_PCI:   r_pci <= wr_data & M_PCI;
                A_SDR:   r_sdr <= wr_data & M_SDR;
                A_PER:   r_per <= wr_data & M_PER;
                default: ;
            endcase
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (rd_addr)
            A_CPU:   rd_data = r_cpu;
            A_PCI:   rd_data = r_pci;
            A_SDR:   rd_data = r_sdr;
            A_PER:   rd_data = r_per;
            default: rd_data = '0;
        endcase
    end

    // Unpack stored bytes into per-output enables.
    always_comb begin
        en.cpu  = r_cpu[N_CPU-1:0];
        en.usb  = r_cpu[BYTE_W-1 -: N_USB];
        en.pci  = r_pci[N_PCI-1:0];
        en.free = r_pci[N_PCI];
        en.sdr  = r_sdr[N_SDR-1:0];
        en.refc = r_per[N_REF-1:0];
        en.apic = r_per[4];
    end
endmodule

// File: rtl/cg_sync2.sv
`timescale 1ns/1ps
// Two-flop synchroniser, W bits wide, into the clk domain.
// Assumes the bits are quasi-static control levels (no bus coherency needed).
module cg_sync2 #(
    parameter int W       = 1,
    parameter bit RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] RV = {W{RST_VAL}};
    logic [W-1:0] meta;

    // Two-stage capture of the asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RV;
            q    <= RV;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cg_gate.sv
`timescale 1ns/1ps
// Per-output gate register. Loads on the falling edge of its clock, so a new
// gate value only takes effect from the next rising edge and a high phase
// is never cut. upd lets a derived clock restrict loads to its low phase.
module cg_gate #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] want,
    output logic [W-1:0] gate
);
    // Update the gate while the gated clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n)
            gate <= '0;
        else if (upd)
            gate <= want;
    end
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
// Clock output gating and stop controller.
// Derives a half-rate PCI clock from cpu_clk, gates every output by its
// register enable, by CPU/PCI stop requests taken from the shared pins when
// mode is low, and by power-down. Assumes mode, stop and pwr_dwn are
// asynchronous levels; power-down acts at once and is not glitch-protected.
module clk_stop_gate
    import cg_pkg::*;
(
    input  logic              bus_clk,
    input  logic              rst_n,
    input  logic              cpu_clk,
    input  logic              usb_clk,
    input  logic              ref_clk,
    input  logic              pwr_dwn,
    input  logic              mode,
    input  logic              sd6_in,
    input  logic              sd7_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [N_CPU-1:0]  cpu_clk_o,
    output logic [N_PCI-1:0]  pci_clk_o,
    output logic              pci_free_o,
    output logic [N_SDR-3:0]  sdram_clk_o,
    output logic              sd6_out,
    output logic              sd6_oe,
    output logic              sd7_out,
    output logic              sd7_oe,
    output logic [N_USB-1:0]  usb_clk_o,
    output logic [N_REF-1:0]  ref_clk_o,
    output logic              apic_clk_o
);
    localparam int SD_LO = N_SDR - 2;               // first shared SDRAM index
    localparam int CW    = 3 + 1 + N_PCI + N_CPU + N_SDR;
    localparam int RW    = N_REF + 1;

    cg_en_t en;
    logic   keep;
    logic   cpu_stop_raw, pci_stop_raw;

    cg_regbank u_regs (
        .clk     (bus_clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .en      (en)
    );

    // Stop requests exist only while the shared pins are inputs.
    always_comb begin
        cpu_stop_raw = ~mode & sd6_in;
        pci_stop_raw = ~mode & sd7_in;
        keep         = ~pwr_dwn;
    end

    // ---------------- CPU-clock domain ----------------
    logic [CW-1:0]    c_sync;
    logic             c_mode, c_cstop, c_pstop, c_free;
    logic [N_PCI-1:0] c_pci;
    logic [N_CPU-1:0] c_cpu;
    logic [N_SDR-1:0] c_sdr;

    cg_sync2 #(.W(CW)) u_sync_cpu (
        .clk   (cpu_clk),
        .rst_n (rst_n),
        .d     ({mode, cpu_stop_raw, pci_stop_raw, en.free, en.pci, en.cpu, en.sdr}),
        .q     (c_sync)
    );

    assign {c_mode, c_cstop, c_pstop, c_free, c_pci, c_cpu, c_sdr} = c_sync;

    // Half-rate PCI source; runs regardless of stop requests.
    logic pci_div;
    always_ff @(posedge cpu_clk) begin
        if (!rst_n) pci_div <= 1'b0;
        else        pci_div <= ~pci_div;
    end

    logic [N_CPU-1:0] want_cpu, g_cpu;
    logic [N_PCI:0]   want_pci, g_pci;
    logic [N_SDR-1:0] want_sdr, g_sdr;

    assign want_cpu = c_cpu & ~{N_CPU{c_cstop}};
    assign want_pci = {c_free, c_pci & ~{N_PCI{c_pstop}}};

    // Shared SDRAM clocks are only enabled while mode selects outputs.
    for (genvar i = 0; i < N_SDR; i++) begin : g_sdw
        if (i >= SD_LO) begin : g_shared
            assign want_sdr[i] = c_sdr[i] & c_mode;
        end else begin : g_plain
            assign want_sdr[i] = c_sdr[i];
        end
    end

    cg_gate #(.W(N_CPU)) u_gate_cpu (
        .clk (cpu_clk), .rst_n (rst_n), .upd (1'b1), .want (want_cpu), .gate (g_cpu)
    );
    cg_gate #(.W(N_SDR)) u_gate_sdr (
        .clk (cpu_clk), .rst_n (rst_n), .upd (1'b1), .want (want_sdr), .gate (g_sdr)
    );
    // PCI gates load only while the divided clock is low.
    cg_gate #(.W(N_PCI+1)) u_gate_pci (
        .clk (cpu_clk), .rst_n (rst_n), .upd (~pci_div), .want (want_pci), .gate (g_pci)
    );

    // ---------------- peripheral-clock domain ----------------
    logic [N_USB-1:0] u_en, g_usb;
    cg_sync2 #(.W(N_USB)) u_sync_usb (
        .clk (usb_clk), .rst_n (rst_n), .d (en.usb), .q (u_en)
    );
    cg_gate #(.W(N_USB)) u_gate_usb (
        .clk (usb_clk), .rst_n (rst_n), .upd (1'b1), .want (u_en), .gate (g_usb)
    );

    // ---------------- reference-clock domain ----------------
    logic [RW-1:0] r_en, g_ref;
    cg_sync2 #(.W(RW)) u_sync_ref (
        .clk (ref_clk), .rst_n (rst_n), .d ({en.apic, en.refc}), .q (r_en)
    );
    cg_gate #(.W(RW)) u_gate_ref (
        .clk (ref_clk), .rst_n (rst_n), .upd (1'b1), .want (r_en), .gate (g_ref)
    );

    // ---------------- output gating ----------------
    // Each output is its source clock ANDed with its gate and power-down.
    always_comb begin
        cpu_clk_o   = {N_CPU{cpu_clk & keep}} & g_cpu;
        pci_clk_o   = {N_PCI{pci_div & keep}} & g_pci[N_PCI-1:0];
        pci_free_o  = pci_div & keep & g_pci[N_PCI];
        sdram_clk_o = {SD_LO{cpu_clk & keep}} & g_sdr[SD_LO-1:0];
        sd6_out     = cpu_clk & keep & g_sdr[SD_LO];
        sd7_out     = cpu_clk & keep & g_sdr[SD_LO+1];
        sd6_oe      = mode;
        sd7_oe      = mode;
        usb_clk_o   = {N_USB{usb_clk & keep}} & g_usb;
        ref_clk_o   = {N_REF{ref_clk & keep}} & g_ref[N_REF-1:0];
        apic_clk_o  = ref_clk & keep & g_ref[N_REF];
    end
endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
// Assertion checker for clk_stop_gate, attached with bind below.
// Observes ports plus synchronised stop levels and gate registers.
module clk_stop_gate_chk
    import cg_pkg::*;
(
    input logic              bus_clk,
    input logic              cpu_clk,
    input logic              usb_clk,
    input logic              ref_clk,
    input logic              rst_n,
    input logic              pwr_dwn,
    input logic              mode,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [BYTE_W-1:0] rd_data,
    input logic [N_CPU-1:0]  cpu_clk_o,
    input logic [N_PCI-1:0]  pci_clk_o,
    input logic              pci_free_o,
    input logic [N_SDR-3:0]  sdram_clk_o,
    input logic [N_REF-1:0]  ref_clk_o,
    input logic              apic_clk_o,
    input logic              c_cstop,
    input logic              c_pstop,
    input logic              pci_div,
    input logic [N_CPU-1:0]  g_cpu,
    input logic [N_PCI:0]    g_pci,
    input logic [N_SDR-1:0]  g_sdr,
    input logic [N_USB-1:0]  g_usb,
    input logic [N_REF:0]    g_ref
);
    // R1
    reset_all_on_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
        ($rose(rst_n) && rd_addr == A_SDR) |-> rd_data == 8'hFF)
        else $error("enable byte not all-on after reset");

    // R2
    unused_addr_zero_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (rd_addr != A_CPU && rd_addr != A_PCI && rd_addr != A_SDR && rd_addr != A_PER)
        |-> rd_data == '0)
        else $error("unused address read non-zero");

    // R2
    rsv_bits_zero_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (rd_addr == A_CPU) |-> rd_data[5:4] == 2'b00)
        else $error("reserved bits read non-zero");

    // R4
    cpu_stop_low_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        $past(c_cstop) |-> cpu_clk_o == '0)
        else $error("CPU clock high during stop");

    // R5
    pci_stop_low_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        ($past(c_pstop) && $past(c_pstop, 2)) |-> pci_clk_o == '0)
        else $error("PCI clock high during stop");

    // R6
    mode_blocks_stop_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        ($past(mode) && $past(mode, 2) && $past(mode, 3)) |-> !c_cstop && !c_pstop)
        else $error("stop active while pins are outputs");

    // R7
    pd_cpu_dom_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        pwr_dwn |-> (cpu_clk_o == '0 && pci_clk_o == '0 && !pci_free_o && sdram_clk_o == '0))
        else $error("CPU-domain output high in power-down");

    // R7
    pd_ref_dom_chk: assert property (@(negedge ref_clk) disable iff (!rst_n)
        pwr_dwn |-> (ref_clk_o == '0 && !apic_clk_o))
        else $error("reference output high in power-down");

    // R10
    pci_phase_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        (pci_clk_o != '0) |-> pci_div)
        else $error("PCI output high outside divided high phase");

    // R9
    always @(g_cpu or g_sdr) begin
        no_runt_cpu_chk: assert (!rst_n || !cpu_clk)
            else $error("CPU-domain gate moved while clock high");
    end

    // R9
    always @(g_pci) begin
        no_runt_pci_chk: assert (!rst_n || !pci_div)
            else $error("PCI gate moved while PCI clock high");
    end

    // R9
    always @(g_usb) begin
        no_runt_usb_chk: assert (!rst_n || !usb_clk)
            else $error("peripheral gate moved while clock high");
    end

    // R9
    always @(g_ref) begin
        no_runt_ref_chk: assert (!rst_n || !ref_clk)
            else $error("reference gate moved while clock high");
    end
endmodule

bind clk_stop_gate clk_stop_gate_chk u_chk (
    .bus_clk     (bus_clk),
    .cpu_clk     (cpu_clk),
    .usb_clk     (usb_clk),
    .ref_clk     (ref_clk),
    .rst_n       (rst_n),
    .pwr_dwn     (pwr_dwn),
    .mode        (mode),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .cpu_clk_o   (cpu_clk_o),
    .pci_clk_o   (pci_clk_o),
    .pci_free_o  (pci_free_o),
    .sdram_clk_o (sdram_clk_o),
    .ref_clk_o   (ref_clk_o),
    .apic_clk_o  (apic_clk_o),
    .c_cstop     (c_cstop),
    .c_pstop     (c_pstop),
    .pci_div     (pci_div),
    .g_cpu       (g_cpu),
    .g_pci       (g_pci),
    .g_sdr       (g_sdr),
    .g_usb       (g_usb),
    .g_ref       (g_ref)
);

// File: tb/test_clk_stop_gate.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural register/output model, every-clock
// read-back comparison, edge counting and pulse-width monitoring.
module test_clk_stop_gate;
    logic       bus_clk = 0, cpu_clk = 0, usb_clk = 0, ref_clk = 0;
    logic       rst_n = 0, pwr_dwn = 0, mode = 1, sd6_in = 0, sd7_in = 0;
    logic       wr_en = 0;
    logic [2:0] wr_addr = 0, rd_addr = 3'd3;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic [3:0] cpu_o;
    logic [5:0] pci_o, sdr_o;
    logic       free_o, sd6_out, sd6_oe, sd7_out, sd7_oe, apic_o;
    logic [1:0] usb_o, ref_o;

    always #10   bus_clk = ~bus_clk;   // 50 MHz
    always #7.5  cpu_clk = ~cpu_clk;
    always #10.5 usb_clk = ~usb_clk;
    always #35   ref_clk = ~ref_clk;

    clk_stop_gate i_clk_stop_gate (
        .bus_clk (bus_clk), .rst_n (rst_n), .cpu_clk (cpu_clk), .usb_clk (usb_clk),
        .ref_clk (ref_clk), .pwr_dwn (pwr_dwn), .mode (mode), .sd6_in (sd6_in),
        .sd7_in (sd7_in), .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_addr (rd_addr), .rd_data (rd_data), .cpu_clk_o (cpu_o), .pci_clk_o (pci_o),
        .pci_free_o (free_o), .sdram_clk_o (sdr_o), .sd6_out (sd6_out), .sd6_oe (sd6_oe),
        .sd7_out (sd7_out), .sd7_oe (sd7_oe), .usb_clk_o (usb_o), .ref_clk_o (ref_o),
        .apic_clk_o (apic_o)
    );

    // bit map: 0-3 cpu, 4-9 pci, 10 free, 11-16 sdram0-5, 17 sd6, 18 sd7,
    // 19-20 usb, 21-22 ref, 23 apic
    logic [23:0] obs;
    assign obs = {apic_o, ref_o, usb_o, sd7_out, sd6_out, sdr_o, free_o, pci_o, cpu_o};

    int checks = 0, fails = 0, runts = 0, phase_bad = 0;
    int cnt [24];
    realtime rise_t [24];
    logic [23:0] prev = '0;
    bit pd_guard = 0, cmp_on = 0, done = 0;
    logic [7:0] m [8];

    function automatic logic [7:0] mask_of(input int a);
        case (a)
            1: return 8'hCF;
            2: return 8'h7F;
            3: return 8'hFF;
            5: return 8'h13;
            default: return 8'h00;
        endcase
    endfunction

    function automatic real half_of(input int i);
        if (i >= 4 && i <= 10) return 15.0;
        if (i == 19 || i == 20) return 10.5;
        if (i >= 21) return 35.0;
        return 7.5;
    endfunction

    function automatic logic [23:0] expect_vec();
        logic [23:0] e;
        logic cst, pst;
        cst = !mode && sd6_in;
        pst = !mode && sd7_in;
        for (int i = 0; i < 4; i++) e[i] = m[1][i] && !cst;
        for (int i = 0; i < 6; i++) e[4+i] = m[2][i] && !pst;
        e[10] = m[2][6];
        for (int i = 0; i < 6; i++) e[11+i] = m[3][i];
        e[17] = m[3][6] && mode;
        e[18] = m[3][7] && mode;
        e[19] = m[1][6]; e[20] = m[1][7];
        e[21] = m[5][0]; e[22] = m[5][1]; e[23] = m[5][4];
        if (pwr_dwn) e = '0;
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Edge counter and high-pulse width monitor for every output.
    always @(obs) begin
        for (int i = 0; i < 24; i++) begin
            if (obs[i] && !prev[i]) begin
                cnt[i]++;
                rise_t[i] = $realtime;
            end else if (!obs[i] && prev[i]) begin
                if (!pd_guard && ($realtime - rise_t[i]) < half_of(i) - 0.5) runts++;
            end
        end
        prev = obs;
    end

    // R10: stoppable PCI clocks high only together with the free PCI clock.
    always @(posedge cpu_clk) begin
        #2;
        if (rst_n && !pwr_dwn && m[2][6] && pci_o != 0 && !free_o) phase_bad++;
    end

    // R2: read-back compared with the model on every bus clock.
    always @(negedge bus_clk) begin
        if (cmp_on)
            check(rd_data == (m[rd_addr] & mask_of(rd_addr)), "R2", "readback",
                  rd_data, m[rd_addr] & mask_of(rd_addr));
    end

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge bus_clk);
        wr_en = 1; wr_addr = a[2:0]; wr_data = d;
        @(posedge bus_clk); #1;
        wr_en = 0;
        m[a] = d & mask_of(a);
    endtask

    task automatic rd_chk(input int a, input logic [7:0] exp, input string req);
        @(posedge bus_clk); #1;
        rd_addr = a[2:0];
        #5;
        check(rd_data == exp, req, $sformatf("read addr %0d", a), rd_data, exp);
    endtask

    task automatic out_chk(input string req);
        logic [23:0] e;
        int base [24];
        int d [24];
        #600;
        e = expect_vec();
        for (int i = 0; i < 24; i++) base[i] = cnt[i];
        #500;
        for (int i = 0; i < 24; i++) begin
            d[i] = cnt[i] - base[i];
            if (e[i]) check(d[i] > 0, req, $sformatf("output %0d toggles", i), d[i], 1);
            else      check(d[i] == 0 && obs[i] == 0, req,
                            $sformatf("output %0d held low", i), d[i], 0);
        end
        if (e[0] && e[10])
            check((2*d[10] - d[0]) <= 2 && (d[0] - 2*d[10]) <= 2, "R8",
                  "cpu edges vs twice pci edges", d[0], 2*d[10]);
        check(sd6_oe == mode && sd7_oe == mode, "R6", "shared pin enables",
              {sd6_oe, sd7_oe}, {mode, mode});
    endtask

    initial begin
        for (int a = 0; a < 8; a++) m[a] = mask_of(a);
        repeat (10) @(posedge bus_clk);
        #3;
        check(obs == 0, "R1", "outputs low in reset", obs, 0);
        rst_n = 1;
        // R1: reset values and outputs running
        rd_chk(3, 8'hFF, "R1");
        rd_chk(2, 8'h7F, "R1");
        rd_chk(1, 8'hCF, "R1");
        rd_chk(5, 8'h13, "R1");
        cmp_on = 1;
        out_chk("R1");

        // R2/R3: selective enables with reserved bits written high
        wr(1, 8'h3A);
        wr(2, 8'h55);
        wr(3, 8'hA5);
        wr(5, 8'hFE);
        rd_chk(1, 8'h0A, "R2");
        rd_chk(5, 8'h12, "R2");
        out_chk("R3");

        // R2: unused addresses ignored
        wr(4, 8'hFF); wr(6, 8'hFF); wr(0, 8'hFF); wr(7, 8'hFF);
        rd_chk(4, 8'h00, "R2");
        rd_chk(6, 8'h00, "R2");
        out_chk("R2");

        wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'hFF); wr(5, 8'hFF);
        rd_addr = 3'd2;

        // R4: CPU stop via shared pin 6
        mode = 0; sd6_in = 1; sd7_in = 0;
        out_chk("R4");
        // R5: PCI stop via shared pin 7, free clock keeps running
        sd6_in = 0; sd7_in = 1;
        out_chk("R5");
        // R6: pins as outputs, stop inputs ignored
        mode = 1; sd6_in = 1; sd7_in = 1;
        out_chk("R6");
        mode = 0; sd6_in = 0; sd7_in = 0;
        out_chk("R6");

        // R9: misaligned rapid stop toggling
        for (int k = 0; k < 60; k++) begin
            sd6_in = ~sd6_in;
            #(3 + (k * 7) % 23);
            if (k % 3 == 0) sd7_in = ~sd7_in;
            #(2 + (k * 5) % 17);
        end
        sd6_in = 0; sd7_in = 0;
        out_chk("R9");
        check(runts == 0, "R9", "short high pulses", runts, 0);
        check(phase_bad == 0, "R10", "PCI phase mismatches", phase_bad, 0);

        // R7: power-down forces every output low at once
        pd_guard = 1;
        pwr_dwn = 1;
        for (int k = 0; k < 5; k++) begin
            #(13 + k * 9);
            check(obs == 0, "R7", "outputs in power-down", obs, 0);
        end
        out_chk("R7");
        pwr_dwn = 0;
        #300;
        pd_guard = 0;
        mode = 1;
        out_chk("R7");
        check(runts == 0, "R9", "short high pulses at end", runts, 0);
        check(phase_bad == 0, "R10", "PCI phase at end", phase_bad, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule